// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block sits on an I/O-space register bus and handles three external interrupt pins. The first pin is shared between a bus-hold function and an interrupt. A mode bit chooses whether both edges of that pin or only its falling edge raise a one-cycle request, `irq1_req`. The other two pins, called A and B here, each have an enable (mask) bit and a pending flag. When an enabled pin sees a falling edge, its flag is set and the shared pulse `irq23_set` fires for one cycle. A downstream flag register uses that pulse to record that either pin needs service. Software clears a pending flag by writing 1 to its bit.

Each pin passes through a two-flop synchronizer. The synchronized level is then compared with its value one cycle earlier, so each edge gives exactly one request cycle. The bus has no back-pressure. A write takes effect at the clock edge on which `io_en` and `io_we` are high. Read data is combinational and valid in the same cycle as `io_en` high with `io_we` low. There is no valid/ready handshake because the bus carries single register accesses and never a stream.

Top module: `xint_ctrl`

## Requirements
- R1: The register answers only at I/O address 0xFFEC. A read of any other address returns 0, and a write to any other address changes nothing.
- R2: Read data bits 15 to 5 are always 0, and writes to those bits are ignored.
- R3: After reset, all five control bits are 0, and `irq1_req` and `irq23_set` are low while the pins stay high.
- R4: With bit 4 = 0, a falling edge and a rising edge on `ext_h_pin` each make `irq1_req` high for one cycle. That cycle follows the second rising clock edge after the pin changes.
- R5: With bit 4 = 1, only a falling edge on `ext_h_pin` pulses `irq1_req`. A rising edge gives no pulse.
- R6: With bit 0 = 1, a falling edge on `ext_a_pin` sets bit 2. With bit 1 = 1, a falling edge on `ext_b_pin` sets bit 3. In both cases `irq23_set` pulses in the same cycle as the request, and the flag reads 1 from the following cycle.
- R7: With its enable bit at 0, a falling edge on pin A or pin B sets no flag and gives no `irq23_set` pulse.
- R8: Writing 1 to bit 2 or bit 3 clears that flag. Writing 0 to it leaves the flag unchanged.
- R9: A hardware set and a write-1 clear that reach the same flag on the same clock edge leave the flag at 1.
- R10: Bits 4, 1 and 0 are plain read/write bits, and each reads back the last value written.
- R11: A rising edge on pin A or pin B sets no flag and gives no pulse, whatever the enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | Bus access strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data (combinational) |
| ext_h_pin | input | 1 | Hold / interrupt-1 pin, asynchronous |
| ext_a_pin | input | 1 | Interrupt pin A, asynchronous, active falling edge |
| ext_b_pin | input | 1 | Interrupt pin B, asynchronous, active falling edge |
| irq1_req | output | 1 | One-cycle interrupt-1 request |
| irq23_set | output | 1 | One-cycle set pulse for the shared A/B interrupt flag |

## Verification
A vector table applies a falling edge and then a rising edge to each of the three pins. It does this under both edge modes and under every useful enable setting. This separates edges that must be accepted from edges that must be ignored, and shows that one pin's edge never shows up on another pin's output. Directed cases then cover the points the table cannot reach: pins A and B falling together, a write-1 clear landing on the same edge as a set, writes of 0 to the flags, and writes to the wrong address or to the reserved bits.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CTRL_W = 5;
  localparam int NPINS  = 3;

  // Field positions decoded by software
  localparam int B_MODE   = 4;
  localparam int B_FLAG_B = 3;
  localparam int B_FLAG_A = 2;
  localparam int B_EN_B   = 1;
  localparam int B_EN_A   = 0;

  // Pin slots in the internal vectors
  localparam int P_H = 0;
  localparam int P_A = 1;
  localparam int P_B = 2;

  typedef struct packed {
    logic fall_only;
    logic flag_b;
    logic flag_a;
    logic en_b;
    logic en_a;
  } ctrl_t;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q_sync
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE}};
      else        chain <= {chain[STAGES-2:0], d_async[i]};
    end
    assign q_sync[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/xint_edge.sv
module xint_edge #(
  parameter int N = 3,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] both_edges,
  output logic [N-1:0] req
);
  logic [N-1:0] lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= {N{IDLE}};
    else        lvl_d <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    logic fall, rise;
    assign fall   = lvl_d[i] & ~lvl[i];
    assign rise   = ~lvl_d[i] & lvl[i];
    assign req[i] = fall | (both_edges[i] & rise);
  end
endmodule

// File: rtl/xint_regs.sv
module xint_regs
  import xint_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 16'hFFEC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              req_a,
  input  logic              req_b,
  output ctrl_t             ctrl_q,
  output logic              grp_set
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic  hit, wr, rd;
  logic  set_a, set_b, clr_a, clr_b;
  ctrl_t ctrl_d;
  logic  unused_rsvd;

  assign hit = io_en && (io_addr == BASE);
  assign wr  = hit && io_we;
  assign rd  = hit && !io_we;

  assign set_a = req_a & ctrl_q.en_a;
  assign set_b = req_b & ctrl_q.en_b;
  assign clr_a = wr & io_wdata[B_FLAG_A];
  assign clr_b = wr & io_wdata[B_FLAG_B];
  assign unused_rsvd = ^io_wdata[DATA_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d.fall_only = io_wdata[B_MODE];
      ctrl_d.en_b      = io_wdata[B_EN_B];
      ctrl_d.en_a      = io_wdata[B_EN_A];
    end
    // set takes priority over a simultaneous clear
    ctrl_d.flag_a = set_a | (ctrl_q.flag_a & ~clr_a);
    ctrl_d.flag_b = set_b | (ctrl_q.flag_b & ~clr_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign io_rdata = rd ? {{PAD_W{1'b0}}, ctrl_q} : '0;
  assign grp_set  = set_a | set_b;
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 16'hFFEC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              ext_h_pin,
  input  logic              ext_a_pin,
  input  logic              ext_b_pin,
  output logic              irq1_req,
  output logic              irq23_set
);
  logic [NPINS-1:0] pins_raw, pins_s, both, req;
  ctrl_t            ctrl_q;

  assign pins_raw = {ext_b_pin, ext_a_pin, ext_h_pin};

  xint_sync #(.N(NPINS), .STAGES(2), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pins_raw), .q_sync(pins_s)
  );

  always_comb begin
    both      = '0;
    both[P_H] = ~ctrl_q.fall_only;
  end

  xint_edge #(.N(NPINS), .IDLE(1'b1)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pins_s), .both_edges(both), .req(req)
  );

  xint_regs #(.BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .io_en(io_en), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .req_a(req[P_A]), .req_b(req[P_B]),
    .ctrl_q(ctrl_q), .grp_set(irq23_set)
  );

  assign irq1_req = req[P_H];
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
  import xint_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              io_en,
  input logic              io_we,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic              irq1_req,
  input logic              irq23_set,
  input ctrl_t             ctrl_q,
  input logic [NPINS-1:0]  pins_s
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[DATA_W-1:CTRL_W] == '0);

  // R1
  off_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != 16'hFFEC) |-> (io_rdata == '0));

  // R6
  grp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq23_set |=> (ctrl_q.flag_a || ctrl_q.flag_b));

  // R7
  mask_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en_a && !ctrl_q.flag_a) |=> !ctrl_q.flag_a);

  // R7
  mask_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en_b && !ctrl_q.flag_b) |=> !ctrl_q.flag_b);

  // R5
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.fall_only && irq1_req) |-> !pins_s[P_H]);

  // R8
  w1c_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_en && io_we && io_addr == 16'hFFEC && io_wdata[B_FLAG_A] && !irq23_set)
      |=> !ctrl_q.flag_a);
endmodule

bind xint_ctrl xint_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_en(io_en), .io_we(io_we),
  .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .irq1_req(irq1_req), .irq23_set(irq23_set),
  .ctrl_q(ctrl_q), .pins_s(pins_s)
);

// File: tb/xint_ctrl_tb_top.sv
module xint_ctrl_tb_top;
  localparam logic [15:0] REG = 16'hFFEC;
  localparam int NV = 13;
  // {mode, en_b, en_a, pin[1:0], fall, exp_req1, exp_set, exp_fb, exp_fa}
  localparam logic [9:0] VEC [NV] = '{
    10'b0_00_00_1_1_0_00,  // R4 H fall mode0
    10'b0_00_00_0_1_0_00,  // R4 H rise mode0
    10'b1_00_00_1_1_0_00,  // R5 H fall mode1
    10'b1_00_00_0_0_0_00,  // R5 H rise mode1
    10'b0_11_00_1_1_0_00,  // R4 H fall, enables on, no flags
    10'b0_01_01_1_0_1_01,  // R6 A fall enabled
    10'b0_10_01_1_0_0_00,  // R7 A fall disabled
    10'b0_10_10_1_0_1_10,  // R6 B fall enabled
    10'b0_01_10_1_0_0_00,  // R7 B fall disabled
    10'b0_11_01_0_0_0_00,  // R11 A rise
    10'b0_11_10_0_0_0_00,  // R11 B rise
    10'b1_11_01_1_0_1_01,  // R6 A fall, mode1
    10'b1_11_10_1_0_1_10   // R6 B fall, mode1
  };

  logic clk = 0, rst_n = 0;
  logic io_en = 0, io_we = 0;
  logic [15:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic ph = 1, pa = 1, pb = 1;
  logic irq1_req, irq23_set;
  int checks = 0, failures = 0;
  int cyc = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  xint_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .io_we(io_we),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ext_h_pin(ph), .ext_a_pin(pa), .ext_b_pin(pb),
    .irq1_req(irq1_req), .irq23_set(irq23_set)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_en = 1; io_we = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_en = 0; io_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    io_en = 1; io_we = 0; io_addr = a;
    #1 d = io_rdata;
    @(negedge clk);
    io_en = 0;
  endtask

  task automatic setpin(input int p, input logic v);
    case (p)
      0: ph = v;
      1: pa = v;
      default: pb = v;
    endcase
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    @(negedge clk);
    chk("R3 irq1_req", {15'b0, irq1_req}, 16'h0);
    chk("R3 irq23_set", {15'b0, irq23_set}, 16'h0);
    rd(REG, rv); chk("R3 reset value", rv, 16'h0000);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [9:0] v;
      logic [15:0] cfg;
      int p;
      v = VEC[i];
      p = int'(v[6:5]);
      cfg = {11'b0, v[9], 2'b11, v[8], v[7]};
      wr(REG, cfg);
      setpin(p, v[4] ? 1'b1 : 1'b0);
      settle();
      wr(REG, cfg);
      @(negedge clk);
      setpin(p, v[4] ? 1'b0 : 1'b1);
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk($sformatf("R4/R5 vec%0d irq1_req", i), {15'b0, irq1_req}, {15'b0, v[3]});
      chk($sformatf("R6/R7/R11 vec%0d irq23_set", i), {15'b0, irq23_set}, {15'b0, v[2]});
      rd(REG, rv);
      chk($sformatf("R6/R7/R11 vec%0d flags", i), {14'b0, rv[3:2]}, {14'b0, v[1:0]});
      setpin(p, 1'b1);
      settle();
    end

    // R10 mode and enables read back
    wr(REG, 16'h001F);
    rd(REG, rv); chk("R10 readback 1", rv, 16'h0013);
    wr(REG, 16'h000C);
    rd(REG, rv); chk("R10 readback 0", rv, 16'h0000);

    // R2 reserved bits dropped
    wr(REG, 16'hFFF3);
    rd(REG, rv); chk("R2 reserved", rv, 16'h0013);

    // R1 other address
    wr(16'hFFED, 16'h0000);
    rd(REG, rv); chk("R1 write elsewhere", rv, 16'h0013);
    rd(16'hFFED, rv); chk("R1 read elsewhere", rv, 16'h0000);

    // Both A and B fall together
    @(negedge clk); pa = 0; pb = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6 both set pulse", {15'b0, irq23_set}, 16'h1);
    rd(REG, rv); chk("R6 both flags", rv, 16'h001F);

    // R8 write 0 has no effect, write 1 clears one flag
    wr(REG, 16'h0013);
    rd(REG, rv); chk("R8 write zero keeps", rv, 16'h001F);
    wr(REG, 16'h0017);
    rd(REG, rv); chk("R8 clear A only", rv, 16'h001B);
    wr(REG, 16'h001B);
    rd(REG, rv); chk("R8 clear B", rv, 16'h0013);
    pa = 1; pb = 1;
    settle();

    // R9 set wins over same-edge clear
    wr(REG, 16'h001F);
    @(negedge clk); pa = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    io_en = 1; io_we = 1; io_addr = REG; io_wdata = 16'h0017;
    @(negedge clk);
    io_en = 0; io_we = 0;
    rd(REG, rv); chk("R9 set beats clear", rv, 16'h0017);
    pa = 1;
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule